// File: doc/BRIEF.md
# Randomized Root Contention Resolver

This block settles a tie between two peer nodes that have each claimed the other as its parent. When the tie is detected, a start strobe puts the controller into contention and it sends idle on the outgoing channel. At the same moment it draws a random bit and picks either a short or a long backoff window. During the backoff it follows what the peer sends. If the window minimum comes up while the latest thing heard from the peer is a request, this node acknowledges it and becomes root. If the latest thing heard is idle, the node sends its own request and waits for the answer. An acknowledge from the peer makes this node child. A request from the peer means both sides collided again, and the contention starts over.

The incoming channel delivers one-cycle strobes for request, acknowledge and idle. The outgoing side raises one-cycle strobes for the same three symbols. A free-running 16-bit LFSR with a nonzero seed supplies the random choice. A weight parameter sets how often the short window is picked, out of 256. The backoff timer counts one step per clock and saturates at its limit. The node acts in the exact cycle the timer equals the chosen window minimum.

Top module: `rc_resolver`

## Requirements
- R1: After reset the block is dormant: no send strobe, isRoot and isChild low, and receive strobes have no effect until start.
- R2: In the cycle after a start strobe, txIdle is high for exactly one cycle, provided rxIdle is not high in that cycle.
- R3: The first send strobe after a txIdle (txAck or txReq) comes exactly FAST_MIN+1 = 77 or SLOW_MIN+1 = 160 cycles after the txIdle cycle, with no other send strobe in between.
- R4: If the peer's most recent strobe during the backoff is a request, or the peer sent nothing since contention began, the node raises txAck and isRoot is high from the next cycle on.
- R5: If the most recent peer strobe during the backoff is idle, the node raises txReq. Later, an rxAck makes isChild high from the following cycle on.
- R6: After txReq, an rxReq sends the node back to contention. txIdle is low in the rxReq cycle and high in the next cycle, and the new backoff ends in txAck when no peer strobe arrives.
- R7: An rxIdle in the first contention cycle suppresses txIdle in that cycle. The idle is sent one cycle later, and that backoff ends in txReq.
- R8: If rxIdle in the first contention cycle is followed by rxReq in the next one, txIdle is again suppressed. The idle is sent one cycle later, and the backoff ends in txAck.
- R9: A peer strobe during the backoff changes only which symbol is sent at its end, never when: the R3 delay still holds.
- R10: At most one send strobe is high in any cycle, isRoot and isChild are never both high, and once either is high it stays high with no send strobe, whatever is received, until the next start.
- R11: Over repeated contentions with the default weight of 128, both the short and the long window are drawn.
- R12: A start strobe in any state clears isRoot and isChild and begins a new contention, with txIdle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin (or restart) contention |
| rxReq | input | 1 | Peer request received (one-cycle strobe) |
| rxAck | input | 1 | Peer acknowledge received (one-cycle strobe) |
| rxIdle | input | 1 | Peer idle received (one-cycle strobe) |
| txReq | output | 1 | Send request strobe |
| txAck | output | 1 | Send acknowledge strobe |
| txIdle | output | 1 | Send idle strobe |
| isRoot | output | 1 | Contention resolved with this node as root |
| isChild | output | 1 | Contention resolved with this node as child |

## Verification
The bench builds the block with its default parameters: windows of 76..85 and 159..167 steps, a timer limit of 168, and a fast weight of 128. So each backoff takes its real length, and either window can show up in any run. Because the LFSR runs freely and the contentions begin at varying times, about two dozen back-to-back contentions sample enough random bits to see both window lengths. The exact delay can then be checked against whichever of the two lengths appears. Peer strobes are injected at chosen cycles of the backoff and of the request-sent wait. This reaches every state and both outcomes, including a repeated collision.

// File: rtl/rc_pkg.sv
package rc_pkg;

  typedef enum logic [3:0] {
    ST_CONTEND      = 4'd0,
    ST_CONTEND_IDLE = 4'd1,
    ST_FAST_REQ     = 4'd2,
    ST_SLOW_REQ     = 4'd3,
    ST_FAST_IDLE    = 4'd4,
    ST_SLOW_IDLE    = 4'd5,
    ST_REQ_SENT     = 4'd6,
    ST_NEAR_ROOT    = 4'd7,
    ST_NEAR_CHILD   = 4'd8,
    ST_DORMANT      = 4'd15
  } rcState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic tmrClear;
    logic tmrRun;
  } rcCmd_t;

  // datapath -> control status
  typedef struct packed {
    logic fastDue;
    logic slowDue;
    logic pickFast;
  } rcStat_t;

endpackage

// File: rtl/rc_datapath.sv
module rc_datapath
  import rc_pkg::*;
#(
  parameter int          FAST_MIN    = 76,
  parameter int          SLOW_MIN    = 159,
  parameter int          TMR_LIMIT   = 168,
  parameter int          FAST_WEIGHT = 128,
  parameter logic [15:0] LFSR_SEED   = 16'hACE1,
  localparam int         TW          = $clog2(TMR_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  rcCmd_t        cmd,
  output rcStat_t       stat,
  output logic [TW-1:0] timer
);

  logic [15:0] lfsr;
  logic        feedback;
  logic        coin;

  // backoff timer: cleared on idle send, counts while waiting, saturates
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (cmd.tmrClear) begin
      timer <= '0;
    end else if (cmd.tmrRun && (timer < TW'(TMR_LIMIT))) begin
      timer <= timer + 1'b1;
    end
  end

  // free-running maximal-length LFSR, taps 16,15,13,4
  assign feedback = lfsr[15] ^ lfsr[14] ^ lfsr[12] ^ lfsr[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr <= LFSR_SEED;
    end else begin
      lfsr <= {lfsr[14:0], feedback};
    end
  end

  // weighted coin: fast when low byte falls below the weight (out of 256)
  generate
    if (FAST_WEIGHT >= 256) begin : g_always_fast
      assign coin = 1'b1;
    end else if (FAST_WEIGHT <= 0) begin : g_always_slow
      assign coin = 1'b0;
    end else begin : g_weighted
      assign coin = (lfsr[7:0] < 8'(FAST_WEIGHT));
    end
  endgenerate

  assign stat.fastDue  = (timer == TW'(FAST_MIN));
  assign stat.slowDue  = (timer == TW'(SLOW_MIN));
  assign stat.pickFast = coin;

endmodule

// File: rtl/rc_ctrl.sv
module rc_ctrl
  import rc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     rxReq,
  input  logic     rxAck,
  input  logic     rxIdle,
  input  rcStat_t  stat,
  output rcCmd_t   cmd,
  output rcState_e state,
  output logic     txReq,
  output logic     txAck,
  output logic     txIdle
);

  rcState_e nextState;
  logic     waitFast;
  logic     peerAsks;
  logic     due;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_DORMANT;
    end else begin
      state <= nextState;
    end
  end

  // which window and which peer view the current wait state holds,
  // with the view updated by a strobe arriving in this cycle
  always_comb begin
    waitFast = (state == ST_FAST_REQ) || (state == ST_FAST_IDLE);
    peerAsks = (state == ST_FAST_REQ) || (state == ST_SLOW_REQ);
    if (rxReq) begin
      peerAsks = 1'b1;
    end else if (rxIdle) begin
      peerAsks = 1'b0;
    end
    due = waitFast ? stat.fastDue : stat.slowDue;
  end

  always_comb begin
    nextState    = state;
    cmd          = '0;
    txReq        = 1'b0;
    txAck        = 1'b0;
    txIdle       = 1'b0;
    if (start) begin
      nextState    = ST_CONTEND;
      cmd.tmrClear = 1'b1;
    end else begin
      unique case (state)
        ST_CONTEND: begin
          if (rxIdle) begin
            nextState = ST_CONTEND_IDLE;
          end else begin
            txIdle       = 1'b1;
            cmd.tmrClear = 1'b1;
            nextState    = stat.pickFast ? ST_FAST_REQ : ST_SLOW_REQ;
          end
        end
        ST_CONTEND_IDLE: begin
          if (rxReq) begin
            nextState = ST_CONTEND;
          end else begin
            txIdle       = 1'b1;
            cmd.tmrClear = 1'b1;
            nextState    = stat.pickFast ? ST_FAST_IDLE : ST_SLOW_IDLE;
          end
        end
        ST_FAST_REQ, ST_SLOW_REQ, ST_FAST_IDLE, ST_SLOW_IDLE: begin
          if (due) begin
            if (peerAsks) begin
              txAck     = 1'b1;
              nextState = ST_NEAR_ROOT;
            end else begin
              txReq     = 1'b1;
              nextState = ST_REQ_SENT;
            end
          end else begin
            cmd.tmrRun = 1'b1;
            if (waitFast) begin
              nextState = peerAsks ? ST_FAST_REQ : ST_FAST_IDLE;
            end else begin
              nextState = peerAsks ? ST_SLOW_REQ : ST_SLOW_IDLE;
            end
          end
        end
        ST_REQ_SENT: begin
          if (rxReq) begin
            nextState = ST_CONTEND;
          end else if (rxAck) begin
            nextState = ST_NEAR_CHILD;
          end
        end
        default: nextState = state;
      endcase
    end
  end

endmodule

// File: rtl/rc_resolver.sv
module rc_resolver
  import rc_pkg::*;
#(
  parameter int          FAST_MIN    = 76,
  parameter int          FAST_MAX    = 85,
  parameter int          SLOW_MIN    = 159,
  parameter int          SLOW_MAX    = 167,
  parameter int          TMR_LIMIT   = 168,
  parameter int          FAST_WEIGHT = 128,
  parameter logic [15:0] LFSR_SEED   = 16'hACE1
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic rxReq,
  input  logic rxAck,
  input  logic rxIdle,
  output logic txReq,
  output logic txAck,
  output logic txIdle,
  output logic isRoot,
  output logic isChild
);

  localparam int TW = $clog2(TMR_LIMIT + 1);

  rcCmd_t        cmd;
  rcStat_t       stat;
  rcState_e      state;
  logic [TW-1:0] timer;

  rc_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .rxReq  (rxReq),
    .rxAck  (rxAck),
    .rxIdle (rxIdle),
    .stat   (stat),
    .cmd    (cmd),
    .state  (state),
    .txReq  (txReq),
    .txAck  (txAck),
    .txIdle (txIdle)
  );

  rc_datapath #(
    .FAST_MIN    (FAST_MIN),
    .SLOW_MIN    (SLOW_MIN),
    .TMR_LIMIT   (TMR_LIMIT),
    .FAST_WEIGHT (FAST_WEIGHT),
    .LFSR_SEED   (LFSR_SEED)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .cmd   (cmd),
    .stat  (stat),
    .timer (timer)
  );

  assign isRoot  = (state == ST_NEAR_ROOT);
  assign isChild = (state == ST_NEAR_CHILD);

endmodule

// File: rtl/rc_resolver_checker.sv
module rc_resolver_checker
  import rc_pkg::*;
#(
  parameter int FAST_MAX = 85,
  parameter int SLOW_MAX = 167,
  parameter int TW       = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          txReq,
  input logic          txAck,
  input logic          txIdle,
  input logic          isRoot,
  input logic          isChild,
  input rcState_e      state,
  input logic [TW-1:0] timer
);

  p_single_tx_r10: assert property (@(posedge clk) disable iff (!rstN)
    $countones({txReq, txAck, txIdle}) <= 1);

  p_root_child_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(isRoot && isChild));

  p_root_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    (isRoot && !start) |=> isRoot);

  p_child_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    (isChild && !start) |=> isChild);

  p_ack_then_root_r4: assert property (@(posedge clk) disable iff (!rstN)
    txAck |=> isRoot);

  p_req_then_wait_r5: assert property (@(posedge clk) disable iff (!rstN)
    txReq |=> (state == ST_REQ_SENT));

  p_idle_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    txIdle |=> (timer == '0));

  p_fast_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_FAST_REQ) || (state == ST_FAST_IDLE)) |-> (timer <= TW'(FAST_MAX)));

  p_slow_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_SLOW_REQ) || (state == ST_SLOW_IDLE)) |-> (timer <= TW'(SLOW_MAX)));

  p_dormant_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DORMANT) |-> !(txReq || txAck || txIdle));

endmodule

bind rc_resolver rc_resolver_checker #(
  .FAST_MAX (FAST_MAX),
  .SLOW_MAX (SLOW_MAX),
  .TW       (TW)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .txReq   (txReq),
  .txAck   (txAck),
  .txIdle  (txIdle),
  .isRoot  (isRoot),
  .isChild (isChild),
  .state   (state),
  .timer   (timer)
);

// File: tb/rc_resolver_bench.sv
`timescale 1ns/1ps
module rc_resolver_bench;

  localparam int FAST_DELAY = 77;   // FAST_MIN + 1
  localparam int SLOW_DELAY = 160;  // SLOW_MIN + 1

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic rxReq = 1'b0;
  logic rxAck = 1'b0;
  logic rxIdle = 1'b0;
  logic txReq, txAck, txIdle, isRoot, isChild;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rc_resolver u_rc_resolver (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .rxReq   (rxReq),
    .rxAck   (rxAck),
    .rxIdle  (rxIdle),
    .txReq   (txReq),
    .txAck   (txAck),
    .txIdle  (txIdle),
    .isRoot  (isRoot),
    .isChild (isChild)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse start; in the following cycle optionally drive rxIdle
  task automatic kick(input bit peerIdle);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rxIdle = peerIdle;
    #1;
  endtask

  // count cycles from the idle cycle to the first req/ack strobe;
  // injKind 1 = rxIdle, 2 = rxReq at cycle injAt (0 = none)
  task automatic waitAct(input int injAt, input int injKind, input int injAt2, input int injKind2,
                         output int delay, output bit gotAck, output bit extraTx);
    delay = 0;
    gotAck = 1'b0;
    extraTx = 1'b0;
    for (int guard = 0; guard < 400; guard++) begin
      @(negedge clk);
      rxIdle = ((delay + 1 == injAt) && injKind == 1) || ((delay + 1 == injAt2) && injKind2 == 1);
      rxReq  = ((delay + 1 == injAt) && injKind == 2) || ((delay + 1 == injAt2) && injKind2 == 2);
      #1;
      delay++;
      if (txIdle) extraTx = 1'b1;
      if (txAck || txReq) begin
        gotAck = txAck;
        break;
      end
    end
    @(negedge clk);
    rxIdle = 1'b0;
    rxReq = 1'b0;
    #1;
  endtask

  function automatic bit okDelay(input int d);
    return (d == FAST_DELAY) || (d == SLOW_DELAY);
  endfunction

  task automatic t_reset();
    bit quiet = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      rxReq = (i == 1);
      rxIdle = (i == 2);
      rxAck = (i == 3);
      #1;
      if (txReq || txAck || txIdle || isRoot || isChild) quiet = 1'b0;
    end
    @(negedge clk);
    rxAck = 1'b0;
    #1;
    if (txReq || txAck || txIdle || isRoot || isChild) quiet = 1'b0;
    check(quiet, "R1 dormant after reset", int'(quiet), 1);
  endtask

  task automatic t_root();
    int d; bit ack; bit extra; bit held = 1'b1;
    kick(1'b0);
    check(txIdle == 1'b1, "R2 idle after start", int'(txIdle), 1);
    waitAct(0, 0, 0, 0, d, ack, extra);
    check(okDelay(d), "R3 backoff length", d, FAST_DELAY);
    check(!extra, "R3 no idle during backoff", int'(extra), 0);
    check(ack, "R4 quiet peer gives ack", int'(ack), 1);
    check(isRoot && !isChild, "R4 root after ack", int'(isRoot), 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      rxReq = (i == 0); rxIdle = (i == 1); rxAck = (i == 2);
      #1;
      if (!isRoot || isChild || txReq || txAck || txIdle) held = 1'b0;
    end
    @(negedge clk); rxAck = 1'b0; #1;
    check(held, "R10 root holds", int'(held), 1);
  endtask

  task automatic t_child();
    int d; bit ack; bit extra; bit held = 1'b1;
    kick(1'b1);
    check(txIdle == 1'b0, "R7 idle suppressed", int'(txIdle), 0);
    @(negedge clk); rxIdle = 1'b0; #1;
    check(txIdle == 1'b1, "R7 idle one cycle later", int'(txIdle), 1);
    waitAct(0, 0, 0, 0, d, ack, extra);
    check(okDelay(d), "R3 backoff length idle-seen", d, FAST_DELAY);
    check(!ack, "R7 ends in request", int'(ack), 0);
    check(!isChild && !isRoot, "R5 undecided while waiting", int'(isChild), 0);
    rxAck = 1'b1;
    @(negedge clk); rxAck = 1'b0; #1;
    check(isChild && !isRoot, "R5 child after ack", int'(isChild), 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rxReq = (i == 0); rxIdle = (i == 1);
      #1;
      if (!isChild || txReq || txAck || txIdle) held = 1'b0;
    end
    @(negedge clk); rxIdle = 1'b0; #1;
    check(held, "R10 child holds", int'(held), 1);
  endtask

  task automatic t_back_to_zero();
    int d; bit ack; bit extra;
    kick(1'b1);
    @(negedge clk); rxIdle = 1'b0; rxReq = 1'b1; #1;
    check(txIdle == 1'b0, "R8 idle suppressed by req", int'(txIdle), 0);
    @(negedge clk); rxReq = 1'b0; #1;
    check(txIdle == 1'b1, "R8 idle after return", int'(txIdle), 1);
    waitAct(0, 0, 0, 0, d, ack, extra);
    check(ack && okDelay(d), "R8 ends in ack", int'(ack), 1);
  endtask

  task automatic t_flip();
    int d; bit ack; bit extra;
    kick(1'b0);
    waitAct(10, 1, 0, 0, d, ack, extra);
    check(!ack, "R9 idle flips to request", int'(ack), 0);
    check(okDelay(d), "R9 delay unchanged", d, FAST_DELAY);
    kick(1'b0);
    waitAct(5, 1, 40, 2, d, ack, extra);
    check(ack, "R9 req flips back to ack", int'(ack), 1);
    check(okDelay(d), "R9 delay unchanged twice", d, FAST_DELAY);
  endtask

  task automatic t_retry();
    int d; bit ack; bit extra;
    kick(1'b1);
    @(negedge clk); rxIdle = 1'b0; #1;
    waitAct(0, 0, 0, 0, d, ack, extra);
    check(!ack, "R6 reach request-sent", int'(ack), 0);
    rxReq = 1'b1; #1;
    check(txIdle == 1'b0, "R6 no idle in collision cycle", int'(txIdle), 0);
    @(negedge clk); rxReq = 1'b0; #1;
    check(txIdle == 1'b1, "R6 idle after collision", int'(txIdle), 1);
    waitAct(0, 0, 0, 0, d, ack, extra);
    check(ack && okDelay(d), "R6 retry ends in ack", d, FAST_DELAY);
    check(isRoot, "R6 root after retry", int'(isRoot), 1);
  endtask

  task automatic t_restart();
    check(isRoot, "R12 precondition root", int'(isRoot), 1);
    kick(1'b0);
    check(!isRoot && !isChild, "R12 flags cleared", int'(isRoot), 0);
    check(txIdle == 1'b1, "R12 idle after restart", int'(txIdle), 1);
  endtask

  task automatic t_random();
    int d; bit ack; bit extra; int nFast = 0; int nSlow = 0; int nBad = 0;
    for (int run = 0; run < 24; run++) begin
      kick(1'b0);
      waitAct(0, 0, 0, 0, d, ack, extra);
      if (d == FAST_DELAY) nFast++;
      else if (d == SLOW_DELAY) nSlow++;
      else nBad++;
      for (int k = 0; k < run % 3; k++) @(negedge clk);
    end
    check(nBad == 0, "R3 all delays valid", nBad, 0);
    check(nFast > 0, "R11 short window drawn", nFast, 1);
    check(nSlow > 0, "R11 long window drawn", nSlow, 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_root();
    t_child();
    t_back_to_zero();
    t_flip();
    t_retry();
    t_restart();
    t_random();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule